// File: doc/BRIEF.md
# Strap-Polarized Status LED Driver

This block drives four status LEDs for an Ethernet PHY: activity, link, 100 Mb/s speed and full duplex. Each pin doubles as an address strap at reset. The level sampled on a pin at reset decides whether that LED is driven active high or active low from then on.

The activity LED follows carrier sense after a two-flop synchronizer. A hold counter keeps it lit for a parameterized number of clock cycles after carrier drops, so that short bursts stay visible. The default models 128 ms at 50 MHz. The link LED picks the 10 Mb/s or the 100 Mb/s link status according to the current speed. The speed LED is forced on during auto-negotiation and forced off while the port is isolated. The duplex LED mirrors the duplex indication. All four pins leave one output register, already polarity-adjusted.

Top module: `led_status_drv`

## Requirements
- R1: Pin bit mapping is strap_i[0]/led_o[0] activity, [1] link, [2] speed, [3] full duplex. A strap bit of 1 makes that LED active low (pin 0 when lit). A strap bit of 0 makes it active high (pin 1 when lit).
- R2: The polarity bits are taken from strap_i while rst_ni is low and frozen when rst_ni rises. Later changes on strap_i have no effect on any pin until the next reset.
- R3: While rst_ni is low, every LED pin sits at its inactive level, which equals its strap bit.
- R4: The activity LED becomes active three rising edges after crs_i goes high and stays active while crs_i stays high.
- R5: Count the first rising edge at which crs_i is low as edge 1. The activity LED is still active after edge HOLD_CYC+2 and is inactive after edge HOLD_CYC+3.
- R6: A carrier-sense pulse during the hold reloads the hold counter, so the hold timing of R5 restarts from the end of the new pulse.
- R7: The link LED is active when the selected link status is 1. It uses link100_i when speed100_i is 1 and link10_i when speed100_i is 0.
- R8: The speed LED is active when speed100_i or an_busy_i is 1 and isolate_i is 0.
- R9: The speed LED is inactive while isolate_i is 1, regardless of speed or auto-negotiation. It is also inactive at 10 Mb/s with no auto-negotiation running.
- R10: The full-duplex LED is active exactly when full_dup_i is 1.
- R11: Link, speed and duplex pins reflect their inputs after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| strap_i | input | 4 | Address strap levels seen on the LED pins |
| crs_i | input | 1 | Carrier sense, asynchronous |
| link10_i | input | 1 | 10 Mb/s link valid |
| link100_i | input | 1 | 100 Mb/s link valid |
| speed100_i | input | 1 | Operating speed is 100 Mb/s |
| an_busy_i | input | 1 | Auto-negotiation in progress |
| isolate_i | input | 1 | Port isolated |
| full_dup_i | input | 1 | Link in full duplex |
| led_o | output | 4 | LED pins, polarity applied |

## Verification
A vector table walks the combinations of speed, both link statuses, auto-negotiation, isolate and duplex. This separates a link LED that reads the wrong status from one that reads the right one, and shows whether isolate overrides auto-negotiation. The table runs under two different strap patterns, so a polarity swapped on a single pin is caught. The activity path gets a long carrier burst, which measures the hold down to the exact edge. It also gets a short pulse in the middle of a hold, which tells a reloading counter from one that only runs out.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
  localparam int NUM_LED  = 4;
  localparam int LED_ACT  = 0;
  localparam int LED_LINK = 1;
  localparam int LED_SPD  = 2;
  localparam int LED_FDX  = 3;
endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/act_stretch.sv
module act_stretch #(
  parameter int HOLD_CYC = 6_400_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic crs_s_i,
  output logic act_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (crs_s_i)        cnt_q <= CW'(HOLD_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign act_o = crs_s_i || (cnt_q != '0);

  // R6: carrier reloads full hold
  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crs_s_i |=> cnt_q == CW'(HOLD_CYC));
  // R5: hold counts down one per cycle
  a_r5_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!crs_s_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/led_out_stage.sv
module led_out_stage #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] on_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] led_o
);
  logic [N-1:0] on_q;

  for (genvar g = 0; g < N; g++) begin : g_led
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) on_q[g] <= 1'b0;
      else         on_q[g] <= on_i[g];
    end
    // pol 1: active low
    assign led_o[g] = on_q[g] ^ pol_i[g];
  end

  // R3: inactive level during reset
  a_r3_rst_inactive: assert property (@(posedge clk_i)
    !rst_ni |-> led_o == pol_i);
  // R1: one register from intent to pin
  a_r1_pin_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> led_o == ($past(on_i) ^ pol_i));
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
  import led_drv_pkg::*;
#(
  parameter int HOLD_CYC = 6_400_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LED-1:0] strap_i,
  input  logic               crs_i,
  input  logic               link10_i,
  input  logic               link100_i,
  input  logic               speed100_i,
  input  logic               an_busy_i,
  input  logic               isolate_i,
  input  logic               full_dup_i,
  output logic [NUM_LED-1:0] led_o
);
  logic [NUM_LED-1:0] strap_q;
  logic [NUM_LED-1:0] pol;
  logic [NUM_LED-1:0] on_vec;
  logic               crs_s;
  logic               act_on;
  logic               link_ok;

  // load while in reset, frozen after release
  always_ff @(posedge clk_i) begin
    if (!rst_ni) strap_q <= strap_i;
  end

  assign pol = rst_ni ? strap_q : strap_i;

  crs_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (crs_i),
    .q_o   (crs_s)
  );

  act_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .crs_s_i(crs_s),
    .act_o  (act_on)
  );

  assign link_ok = speed100_i ? link100_i : link10_i;

  always_comb begin
    on_vec           = '0;
    on_vec[LED_ACT]  = act_on;
    on_vec[LED_LINK] = link_ok;
    on_vec[LED_SPD]  = !isolate_i && (speed100_i || an_busy_i);
    on_vec[LED_FDX]  = full_dup_i;
  end

  led_out_stage #(.N(NUM_LED)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .on_i  (on_vec),
    .pol_i (pol),
    .led_o (led_o)
  );

  // R2: polarity frozen outside reset
  a_r2_strap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(strap_q));
  // R9: isolate forces speed LED off
  a_r9_isolate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(isolate_i)) |-> led_o[LED_SPD] == strap_q[LED_SPD]);
  // R10: duplex LED tracks input
  a_r10_fdx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(full_dup_i)) |-> led_o[LED_FDX] != strap_q[LED_FDX]);
endmodule

// File: tb/led_status_drv_bench.sv
module led_status_drv_bench;
  localparam int HOLD = 20;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] strap = 4'b0101;
  logic       crs = 1'b0, l10 = 1'b0, l100 = 1'b0, s100 = 1'b0;
  logic       an = 1'b0, iso = 1'b0, fdx = 1'b0;
  logic [3:0] led;
  int         n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  led_status_drv #(.HOLD_CYC(HOLD)) u_led_status_drv (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap), .crs_i(crs),
    .link10_i(l10), .link100_i(l100), .speed100_i(s100), .an_busy_i(an),
    .isolate_i(iso), .full_dup_i(fdx), .led_o(led)
  );

  // {s100,l10,l100,an,iso,fdx} -> expected on {fdx,spd,link}
  localparam logic [8:0] VEC [10] = '{
    {6'b000000, 3'b000},
    {6'b010000, 3'b001},
    {6'b001000, 3'b000},
    {6'b101000, 3'b011},
    {6'b110000, 3'b010},
    {6'b000100, 3'b010},
    {6'b000110, 3'b000},
    {6'b101010, 3'b001},
    {6'b010001, 3'b101},
    {6'b111101, 3'b111}
  };

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: led=%b expected %b", req, got, exp);
    end
  endtask

  task automatic do_reset(logic [3:0] s);
    @(negedge clk);
    rst_ni = 1'b0; strap = s; crs = 1'b0;
    {s100, l10, l100, an, iso, fdx} = '0;
    repeat (3) @(negedge clk);
    chk("R3 reset inactive", led, s);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_table(logic [3:0] s);
    for (int i = 0; i < 10; i++) begin
      {s100, l10, l100, an, iso, fdx} = VEC[i][8:3];
      @(negedge clk); // R11 one edge
      chk("R1/R7/R8/R9/R10/R11 table", led, {VEC[i][2:0], 1'b0} ^ s);
    end
  endtask

  task automatic act_hold(string req, logic [3:0] s);
    for (int k = 1; k <= HOLD + 3; k++) begin
      @(negedge clk);
      if (k == HOLD + 2) chk({req, " still active"}, led & 4'b0001, {3'b000, ~s[0]});
      if (k == HOLD + 3) chk({req, " expired"},      led & 4'b0001, {3'b000,  s[0]});
    end
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: led=%b expected finish", led);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset(4'b0101);
    chk("R1 idle pins", led, 4'b0101);
    run_table(4'b0101);

    // R2: strap change after reset ignored
    {s100, l10, l100, an, iso, fdx} = '0;
    strap = 4'b1010;
    repeat (2) @(negedge clk);
    chk("R2 strap ignored idle", led, 4'b0101);
    fdx = 1'b1; l10 = 1'b1;
    @(negedge clk);
    chk("R2 strap ignored active", led, 4'b1111);
    fdx = 1'b0; l10 = 1'b0;

    // R4: activity after three edges
    crs = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 not yet at edge 2", led & 4'b0001, 4'b0001);
    @(negedge clk);
    chk("R4 active at edge 3", led & 4'b0001, 4'b0000);
    repeat (30) @(negedge clk);
    chk("R4 steady", led & 4'b0001, 4'b0000);

    // R5: stretch
    crs = 1'b0;
    act_hold("R5", 4'b0101);

    // R6: reload during hold
    crs = 1'b1;
    repeat (5) @(negedge clk);
    crs = 1'b0;
    repeat (10) @(negedge clk);
    crs = 1'b1;
    @(negedge clk);
    crs = 1'b0;
    act_hold("R6", 4'b0101);

    // second strap pattern
    do_reset(4'b1010);
    chk("R1 idle pins alt strap", led, 4'b1010);
    run_table(4'b1010);
    crs = 1'b1;
    repeat (4) @(negedge clk);
    crs = 1'b0;
    act_hold("R5 alt strap", 4'b1010);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule